// File: doc/BRIEF.md
# Cartridge ROM/SRAM Chip-Select Decoder

This block sits on a game cartridge between the console's bus and the memories. It looks at four address bits, an active-low cartridge strobe from the console, the console's active-low reset line, and a static strap that chooses between 32 KB-bank and 64 KB-bank wiring. From these inputs it drives five active-low enables: a ROM output enable, a chip select for a battery-backed SRAM, an auxiliary select for an extra device, and two chip selects that split a board with two ROMs into an upper half and a lower half.

The four address inputs are named by lane. Their meaning depends on the strap. In 32 KB-bank mode, `lane_w` is A15, `lane_x` is bank bit 4, `lane_y` is bank bit 5, and `lane_z` is bank bit 6 or a tie-high. In 64 KB-bank mode, `lane_w` is A13, `lane_x` is A14, `lane_y` is bank bit 5, and `lane_z` is A15 or bank bit 6. In 64 KB-bank mode the SRAM window lies in a region that the console does not claim with its strobe. For that reason the SRAM decode in this mode needs the strobe high, while in 32 KB-bank mode it needs the strobe low.

The decode itself is combinational. A parameter selects an output register stage that adds one clock of latency and has a synchronous active-high reset to the idle state. The idle state has all outputs high.

Top module: `cart_chip_select`

## Requirements
- R1: While `reset_n` is 0, every output is 1 (deasserted), for all values of the other inputs.
- R2: With `mode`=0, `reset_n`=1, `cart_n`=0 and `lane_w`=1, `rom_oe_n` is 0. `lane_y`=0 drives `rom_lo_n` to 0 and `lane_y`=1 drives `rom_hi_n` to 0. The other outputs are 1, and `lane_x` and `lane_z` have no effect.
- R3: With `mode`=0, `reset_n`=1 and `cart_n`=0, the input pattern `lane_w`=0, `lane_x`=1, `lane_y`=1, `lane_z`=1 drives `sram_cs_n` alone to 0.
- R4: With `mode`=0, `reset_n`=1 and `cart_n`=0, the input pattern `lane_w`=0, `lane_x`=0, `lane_y`=1, `lane_z`=1 drives `aux_cs_n` alone to 0.
- R5: With `mode`=0 and `cart_n`=1, every output is 1.
- R6: With `mode`=1, `reset_n`=1 and `cart_n`=0, `rom_oe_n` is 0 for every lane value. `lane_y` picks `rom_lo_n` (0) or `rom_hi_n` (1), and `sram_cs_n` and `aux_cs_n` stay 1.
- R7: With `mode`=1, `reset_n`=1 and `cart_n`=1, `sram_cs_n` is 0 exactly when `lane_z`=0, `lane_y`=1, `lane_x`=1 and `lane_w`=1. All other outputs stay 1.
- R8: At most one of `rom_oe_n`, `sram_cs_n` and `aux_cs_n` is 0 at any time. `rom_hi_n` and `rom_lo_n` are never both 0, and either one is 0 only while `rom_oe_n` is 0.
- R9: Every input combination not covered by R2, R3, R4, R6 or R7 leaves all five outputs at 1.
- R10: With `REG_OUT`=1 (the default), outputs follow the inputs one rising clock edge later. When `rst`=1 at a rising edge, all outputs become 1 at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| reset_n | input | 1 | Console reset, active low |
| cart_n | input | 1 | Console cartridge-region strobe, active low |
| mode | input | 1 | Wiring strap: 0 = 32 KB banks, 1 = 64 KB banks |
| lane_w | input | 1 | Address lane W (A15 or A13, depending on mode) |
| lane_x | input | 1 | Address lane X (bank bit 4 or A14) |
| lane_y | input | 1 | Address lane Y (bank bit 5) |
| lane_z | input | 1 | Address lane Z (bank bit 6, tie-high, or A15) |
| rom_oe_n | output | 1 | ROM output enable, active low |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| aux_cs_n | output | 1 | Auxiliary device select, active low |
| rom_hi_n | output | 1 | Upper ROM chip select, active low |
| rom_lo_n | output | 1 | Lower ROM chip select, active low |

## Verification
The only state in this block is the output register. A wrong value held there shows up at the ports for exactly one clock: either a stale enable that overlaps the next access, or a missing enable. The next edge overwrites it. A wrong decode term gives a bad enable pattern in the same cycle, one edge after the input pattern that hits it. That pattern can be two primary enables low at once, a ROM half-select without the output enable, or an SRAM select with the strobe at the wrong polarity. Sweeping all 128 input patterns therefore exposes any broken term within one edge of its pattern.

// File: rtl/cart_sel_pkg.sv
package cart_sel_pkg;

    // Bundled decoder inputs; field order is the bench's bit order.
    typedef struct packed {
        logic reset_n;
        logic cart_n;
        logic mode;
        logic lane_z;
        logic lane_y;
        logic lane_x;
        logic lane_w;
    } csd_in_t;

    // Active-low enables; field order is the bench's bit order.
    typedef struct packed {
        logic rom_oe_n;
        logic sram_cs_n;
        logic aux_cs_n;
        logic rom_hi_n;
        logic rom_lo_n;
    } csd_out_t;

    typedef enum logic {
        WIRING_32K = 1'b0,
        WIRING_64K = 1'b1
    } wiring_e;

    localparam int unsigned CSD_IN_W  = $bits(csd_in_t);
    localparam int unsigned CSD_OUT_W = $bits(csd_out_t);
    localparam csd_out_t    CSD_IDLE  = '1;

    // ROM access, with bank bit 5 choosing which of the two ROM chips.
    function automatic csd_out_t rom_access(input logic upper);
        csd_out_t r;
        r          = CSD_IDLE;
        r.rom_oe_n = 1'b0;
        r.rom_hi_n = ~upper;
        r.rom_lo_n = upper;
        return r;
    endfunction

endpackage

// File: rtl/csd_bank32_dec.sv
module csd_bank32_dec
    import cart_sel_pkg::*;
(
    input  csd_in_t  in_i,
    output csd_out_t out_o
);
    always_comb begin
        out_o = CSD_IDLE;
        if (!in_i.cart_n) begin
            if (in_i.lane_w) begin
                out_o = rom_access(in_i.lane_y);
            end else if (in_i.lane_y && in_i.lane_z) begin
                if (in_i.lane_x) out_o.sram_cs_n = 1'b0;
                else             out_o.aux_cs_n  = 1'b0;
            end
        end
    end
endmodule

// File: rtl/csd_bank64_dec.sv
module csd_bank64_dec
    import cart_sel_pkg::*;
(
    input  csd_in_t  in_i,
    output csd_out_t out_o
);
    logic sram_window;

    // Strobe high: the console leaves this window free for the cartridge.
    assign sram_window = in_i.cart_n && !in_i.lane_z
                       && in_i.lane_y && in_i.lane_x && in_i.lane_w;

    always_comb begin
        out_o = CSD_IDLE;
        if (!in_i.cart_n)     out_o = rom_access(in_i.lane_y);
        else if (sram_window) out_o.sram_cs_n = 1'b0;
    end
endmodule

// File: rtl/csd_out_stage.sv
module csd_out_stage
    import cart_sel_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  csd_out_t d_i,
    output csd_out_t q_o
);
    generate
        if (REG_OUT) begin : g_reg
            csd_out_t q_r;
            always_ff @(posedge clk) begin
                if (rst) q_r <= CSD_IDLE;
                else     q_r <= d_i;
            end
            assign q_o = q_r;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk;
            assign q_o = rst ? CSD_IDLE : d_i;
        end
    endgenerate
endmodule

// File: rtl/cart_chip_select.sv
module cart_chip_select
    import cart_sel_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic reset_n,
    input  logic cart_n,
    input  logic mode,
    input  logic lane_w,
    input  logic lane_x,
    input  logic lane_y,
    input  logic lane_z,
    output logic rom_oe_n,
    output logic sram_cs_n,
    output logic aux_cs_n,
    output logic rom_hi_n,
    output logic rom_lo_n
);
    csd_in_t  pins;
    csd_out_t dec32, dec64, picked, staged;

    assign pins = '{reset_n: reset_n, cart_n: cart_n, mode: mode,
                    lane_z: lane_z, lane_y: lane_y, lane_x: lane_x, lane_w: lane_w};

    csd_bank32_dec u_dec32 (.in_i(pins), .out_o(dec32));
    csd_bank64_dec u_dec64 (.in_i(pins), .out_o(dec64));

    always_comb begin
        if (!pins.reset_n)                     picked = CSD_IDLE;
        else if (wiring_e'(pins.mode) == WIRING_64K) picked = dec64;
        else                                   picked = dec32;
    end

    csd_out_stage #(.REG_OUT(REG_OUT)) u_stage (
        .clk (clk),
        .rst (rst),
        .d_i (picked),
        .q_o (staged)
    );

    assign rom_oe_n  = staged.rom_oe_n;
    assign sram_cs_n = staged.sram_cs_n;
    assign aux_cs_n  = staged.aux_cs_n;
    assign rom_hi_n  = staged.rom_hi_n;
    assign rom_lo_n  = staged.rom_lo_n;
endmodule

// File: rtl/cart_chip_select_chk.sv
module cart_chip_select_chk #(
    parameter bit REG_OUT = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic reset_n,
    input logic cart_n,
    input logic mode,
    input logic lane_w,
    input logic lane_x,
    input logic lane_y,
    input logic lane_z,
    input logic rom_oe_n,
    input logic sram_cs_n,
    input logic aux_cs_n,
    input logic rom_hi_n,
    input logic rom_lo_n
);
    // Inputs aligned to the cycle in which their outputs are visible.
    // seen = {reset_n, cart_n, mode, lane_z, lane_y, lane_x, lane_w}
    logic [6:0] seen;
    logic [4:0] outs;
    assign outs = {rom_oe_n, sram_cs_n, aux_cs_n, rom_hi_n, rom_lo_n};

    generate
        if (REG_OUT) begin : g_align_reg
            always_ff @(posedge clk) begin
                if (rst) seen <= 7'b0;
                else     seen <= {reset_n, cart_n, mode, lane_z, lane_y, lane_x, lane_w};
            end
        end else begin : g_align_comb
            assign seen = {reset_n, cart_n, mode, lane_z, lane_y, lane_x, lane_w};
        end
    endgenerate

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        !seen[6] |-> outs == 5'b11111);

    a_r5_strobe_high_32k: assert property (@(posedge clk) disable iff (rst)
        (seen[6] && seen[5] && !seen[4]) |-> outs == 5'b11111);

    a_r2_rom_half_pick: assert property (@(posedge clk) disable iff (rst)
        (seen[6] && !seen[5] && !seen[4] && seen[0])
        |-> (!rom_oe_n && rom_hi_n == !seen[2] && rom_lo_n == seen[2]));

    a_r7_sram_window_64k: assert property (@(posedge clk) disable iff (rst)
        (seen[6:4] == 3'b111 && seen[3:0] == 4'b0111) |-> !sram_cs_n);

    a_r8_one_primary: assert property (@(posedge clk) disable iff (rst)
        $countones({~rom_oe_n, ~sram_cs_n, ~aux_cs_n}) <= 1);

    a_r8_half_needs_oe: assert property (@(posedge clk) disable iff (rst)
        (!rom_hi_n || !rom_lo_n) |-> (!rom_oe_n && rom_hi_n != rom_lo_n));
endmodule

bind cart_chip_select cart_chip_select_chk #(.REG_OUT(REG_OUT)) chk_i (
    .clk(clk), .rst(rst), .reset_n(reset_n), .cart_n(cart_n), .mode(mode),
    .lane_w(lane_w), .lane_x(lane_x), .lane_y(lane_y), .lane_z(lane_z),
    .rom_oe_n(rom_oe_n), .sram_cs_n(sram_cs_n), .aux_cs_n(aux_cs_n),
    .rom_hi_n(rom_hi_n), .rom_lo_n(rom_lo_n)
);

// File: tb/cart_chip_select_tb_top.sv
`timescale 1ns/1ps
module cart_chip_select_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reset_n = 1'b0, cart_n = 1'b1, mode = 1'b0;
    logic lane_w = 1'b0, lane_x = 1'b0, lane_y = 1'b0, lane_z = 1'b0;
    logic rom_oe_n, sram_cs_n, aux_cs_n, rom_hi_n, rom_lo_n;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cart_chip_select dut_i (
        .clk(clk), .rst(rst), .reset_n(reset_n), .cart_n(cart_n), .mode(mode),
        .lane_w(lane_w), .lane_x(lane_x), .lane_y(lane_y), .lane_z(lane_z),
        .rom_oe_n(rom_oe_n), .sram_cs_n(sram_cs_n), .aux_cs_n(aux_cs_n),
        .rom_hi_n(rom_hi_n), .rom_lo_n(rom_lo_n)
    );

    // stimulus bits {reset_n, cart_n, mode, lane_z, lane_y, lane_x, lane_w}
    // expected bits {rom_oe_n, sram_cs_n, aux_cs_n, rom_hi_n, rom_lo_n}
    localparam int NVEC = 12;
    localparam logic [11:0] VEC [NVEC] = '{
        {7'b0001111, 5'b11111},  // R1 reset low
        {7'b1000001, 5'b01110},  // R2 lower ROM
        {7'b1000101, 5'b01101},  // R2 upper ROM
        {7'b1001110, 5'b10111},  // R3 SRAM
        {7'b1001100, 5'b11011},  // R4 aux
        {7'b1101111, 5'b11111},  // R5 strobe high
        {7'b1010000, 5'b01110},  // R6 lower ROM
        {7'b1010100, 5'b01101},  // R6 upper ROM
        {7'b1110111, 5'b10111},  // R7 SRAM window
        {7'b1111111, 5'b11111},  // R9 lane_z high
        {7'b1000110, 5'b11111},  // R9 lane_z low, 32K
        {7'b1110011, 5'b11111}   // R9 lane_y low, 64K
    };
    localparam string VTAG [NVEC] = '{"R1","R2","R2","R3","R4","R5",
                                      "R6","R6","R7","R9","R9","R9"};

    function automatic logic [4:0] model(input logic [6:0] s);
        logic rn, cn, md, z, y, x, w;
        {rn, cn, md, z, y, x, w} = s;
        if (!rn) return 5'b11111;
        if (!md) begin
            if (cn) return 5'b11111;
            if (w)  return y ? 5'b01101 : 5'b01110;
            if (z && y && x)  return 5'b10111;
            if (z && y && !x) return 5'b11011;
            return 5'b11111;
        end
        if (!cn) return y ? 5'b01101 : 5'b01110;
        if (w && x && y && !z) return 5'b10111;
        return 5'b11111;
    endfunction

    function automatic logic [4:0] outs();
        return {rom_oe_n, sram_cs_n, aux_cs_n, rom_hi_n, rom_lo_n};
    endfunction

    task automatic check(input string tag, input logic [4:0] got, input logic [4:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [6:0] s);
        {reset_n, cart_n, mode, lane_z, lane_y, lane_x, lane_w} = s;
    endtask

    // drive on the falling edge, sample just after the capturing rising edge
    task automatic apply(input logic [6:0] s);
        @(negedge clk);
        drive(s);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 sync reset idle", outs(), 5'b11111);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][11:5]);
            check(VTAG[i], outs(), VEC[i][4:0]);
        end

        // exhaustive sweep against the model, with exclusivity (R8)
        for (int v = 0; v < 128; v++) begin
            logic [4:0] o;
            apply(v[6:0]);
            o = outs();
            check("R9 sweep", o, model(v[6:0]));
            check("R8 exclusive",
                  {($countones({~o[4], ~o[3], ~o[2]}) <= 1),
                   !(!o[1] && !o[0]), (o[1] && o[0]) || !o[4], 2'b11},
                  5'b11111);
        end

        // R2: lane_x and lane_z ignored on a ROM access in 32K mode
        apply(7'b1001011);
        check("R2 lanes x z ignored", outs(), 5'b01110);

        // R10: one edge of latency
        apply(7'b1111111);
        @(negedge clk);
        drive(7'b1000001);
        #1;
        check("R10 before edge", outs(), 5'b11111);
        @(posedge clk);
        #1;
        check("R10 after edge", outs(), 5'b01110);

        // R10: synchronous reset forces idle at the edge
        @(negedge clk);
        rst = 1'b1;
        #1;
        check("R10 rst before edge", outs(), 5'b01110);
        @(posedge clk);
        #1;
        check("R10 rst at edge", outs(), 5'b11111);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R10 rst released", outs(), 5'b01110);

        // R1: reset_n low overrides a 64K SRAM hit
        apply(7'b0110111);
        check("R1 reset overrides", outs(), 5'b11111);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule